// File: doc/BRIEF.md
# Protected Processor Status Register

This block is the 8-bit status register of a small accumulator-style microcontroller core. It holds the data-memory bank selects, two power-state indicators, and the arithmetic flags Z, DC and C. It takes three kinds of input. The first is a register-file write port, so the register can be an ordinary instruction destination. The second is a flag-update port from the ALU, with one strobe per flag. The third is a set of event strobes for power-on, watchdog clear, sleep entry and watchdog time-out.

Two rules protect the register. A direct write can never reach the two power-state bits. Any instruction that updates at least one flag loses its direct write to all three flag bits. Each flag that instruction strobes takes the ALU value, and the other flags keep their contents. The bank bits decode into a one-hot direct-bank select and a base address for direct addressing. The indirect bank bit decodes into an upper-half select and a base address for indirect addressing.

All state updates on the rising clock edge, and the outputs show the new contents one cycle after the inputs are sampled. Power-on is a synchronous strobe with top priority. The flags have no reset value.

Top module: `cpu_status_reg`

## Requirements
- R1: `status` always shows the live contents with bit 7 = indirect bank, bits 6:5 = direct bank (bit 6 high), bit 4 = time-out (TO), bit 3 = power-down (PD), bit 2 = Z, bit 1 = DC, bit 0 = C.
- R2: One cycle after `por` is sampled high, bits 7:5 read 000 and TO and PD read 1. Z, DC and C keep their previous contents.
- R3: A direct write (`wr_en`) never changes TO or PD. With no event strobe, TO and PD hold.
- R4: When `wr_en` is high and no flag strobe is high, bits 7:5 and Z, DC, C all take the matching bits of `wr_data`.
- R5: When any flag strobe is high, the direct write to Z, DC and C is dropped. A strobed flag takes its ALU value and an unstrobed flag holds. Bits 7:5 are still written. A clear with only the Z strobe set therefore gives 000, TO, PD, 1, DC, C.
- R6: `clrwdt` alone sets both TO and PD to 1.
- R7: `sleep_ev` sets TO to 1 and clears PD to 0. When it coincides with `clrwdt`, PD is still cleared.
- R8: `wdt_to` clears TO to 0 and takes priority over `sleep_ev` and `clrwdt` for TO.
- R9: `por` overrides every write, flag update and event in the same cycle.
- R10: `dir_bank_sel` is one-hot with bit n high when bits 6:5 equal n. `dir_base` equals bits 6:5 shifted left by `BANK_AW`, which gives 0x000, 0x080, 0x100 and 0x180 with 128-byte banks.
- R11: `ind_upper` equals bit 7, and `ind_base` equals bit 7 shifted left by `BANK_AW`+1 (0x000 or 0x100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset strobe, synchronous, highest priority |
| wr_en | input | 1 | Register-file write targets this register |
| wr_data | input | 8 | Write data |
| flg_z_we | input | 1 | ALU updates Z |
| flg_dc_we | input | 1 | ALU updates DC |
| flg_c_we | input | 1 | ALU updates C |
| flg_z | input | 1 | New Z value |
| flg_dc | input | 1 | New DC value |
| flg_c | input | 1 | New C value |
| clrwdt | input | 1 | Watchdog-clear event |
| sleep_ev | input | 1 | Sleep-entry event |
| wdt_to | input | 1 | Watchdog time-out event |
| status | output | 8 | Current register contents |
| dir_bank_sel | output | 4 | One-hot direct bank select |
| dir_base | output | BANK_AW+2 | Direct-bank base address |
| ind_upper | output | 1 | Indirect upper-half select |
| ind_base | output | BANK_AW+2 | Indirect base address |

## Verification
The bench builds the block with the default `BANK_AW` of 7, so the base addresses can be checked against the four 128-byte bank boundaries and the two 256-byte halves. At this width every bank code and every combination of write, flag strobe and event can be reached in a few thousand random cycles. A behavioural model treats each flag as unknown after power-on until a write or an ALU update sets it, and it compares only bits it knows. Directed cases cover the clear pattern, simultaneous event strobes and power-on that coincides with other activity.

// File: rtl/cpu_status_reg.sv
module cpu_status_reg #(
  parameter int BANK_AW = 7,
  localparam int ADDR_W = BANK_AW + 2
) (
  input  logic              clk,
  input  logic              por,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              flg_z_we,
  input  logic              flg_dc_we,
  input  logic              flg_c_we,
  input  logic              flg_z,
  input  logic              flg_dc,
  input  logic              flg_c,
  input  logic              clrwdt,
  input  logic              sleep_ev,
  input  logic              wdt_to,
  output logic [7:0]        status,
  output logic [3:0]        dir_bank_sel,
  output logic [ADDR_W-1:0] dir_base,
  output logic              ind_upper,
  output logic [ADDR_W-1:0] ind_base
);

  logic       irp_q;
  logic [1:0] rp_q;
  logic       to_q, pd_q;
  logic       z_q, dc_q, c_q;

  wire flag_inst = flg_z_we | flg_dc_we | flg_c_we;
  wire raw_wr    = wr_en & ~flag_inst;

  always_ff @(posedge clk) begin
    if (por) begin
      irp_q <= 1'b0;
      rp_q  <= 2'b00;
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
    end else begin
      if (wr_en) begin
        irp_q <= wr_data[7];
        rp_q  <= wr_data[6:5];
      end
      if (wdt_to)                to_q <= 1'b0;
      else if (clrwdt | sleep_ev) to_q <= 1'b1;
      if (sleep_ev)              pd_q <= 1'b0;
      else if (clrwdt)           pd_q <= 1'b1;
      if (flg_z_we)      z_q  <= flg_z;
      else if (raw_wr)   z_q  <= wr_data[2];
      if (flg_dc_we)     dc_q <= flg_dc;
      else if (raw_wr)   dc_q <= wr_data[1];
      if (flg_c_we)      c_q  <= flg_c;
      else if (raw_wr)   c_q  <= wr_data[0];
    end
  end

  assign status = {irp_q, rp_q, to_q, pd_q, z_q, dc_q, c_q};

  for (genvar g = 0; g < 4; g++) begin : g_bank
    assign dir_bank_sel[g] = (rp_q == 2'(g));
  end

  assign dir_base  = {rp_q, {BANK_AW{1'b0}}};
  assign ind_upper = irp_q;
  assign ind_base  = {irp_q, {(BANK_AW+1){1'b0}}};

  assert_por_state_R2: assert property (@(posedge clk)
    por |=> status[7:3] == 5'b00011);

  assert_pd_to_hold_R3: assert property (@(posedge clk) disable iff (por)
    (!clrwdt && !sleep_ev && !wdt_to) |=> $stable(status[4:3]));

  assert_raw_write_R4: assert property (@(posedge clk) disable iff (por)
    (wr_en && !flag_inst) |=> status[7:5] == $past(wr_data[7:5]) && status[2:0] == $past(wr_data[2:0]));

  assert_flag_c_R5: assert property (@(posedge clk) disable iff (por)
    flg_c_we |=> status[0] == $past(flg_c));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (por)
    (flag_inst && !flg_z_we) |=> $stable(status[2]));

  assert_clrwdt_R6: assert property (@(posedge clk) disable iff (por)
    (clrwdt && !sleep_ev && !wdt_to) |=> status[4:3] == 2'b11);

  assert_sleep_R7: assert property (@(posedge clk) disable iff (por)
    (sleep_ev && !wdt_to) |=> status[4:3] == 2'b10);

  assert_timeout_R8: assert property (@(posedge clk) disable iff (por)
    wdt_to |=> !status[4]);

  assert_bank_onehot_R10: assert property (@(posedge clk) disable iff (por)
    $countones(dir_bank_sel) == 1);

endmodule

// File: tb/cpu_status_reg_tb.sv
module cpu_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_AW = 7;

  logic clk = 1'b0;
  logic por = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic flg_z_we = 0, flg_dc_we = 0, flg_c_we = 0, flg_z = 0, flg_dc = 0, flg_c = 0;
  logic clrwdt = 0, sleep_ev = 0, wdt_to = 0;
  logic [7:0] status;
  logic [3:0] dir_bank_sel;
  logic [BANK_AW+1:0] dir_base, ind_base;
  logic ind_upper;

  int checks = 0, errors = 0;
  int m_irp, m_rp, m_to, m_pd, m_z, m_dc, m_c;
  bit kz, kdc, kc, started;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_status_reg #(.BANK_AW(BANK_AW)) u_dut (
    .clk(clk), .por(por), .wr_en(wr_en), .wr_data(wr_data),
    .flg_z_we(flg_z_we), .flg_dc_we(flg_dc_we), .flg_c_we(flg_c_we),
    .flg_z(flg_z), .flg_dc(flg_dc), .flg_c(flg_c),
    .clrwdt(clrwdt), .sleep_ev(sleep_ev), .wdt_to(wdt_to),
    .status(status), .dir_bank_sel(dir_bank_sel), .dir_base(dir_base),
    .ind_upper(ind_upper), .ind_base(ind_base));

  always @(posedge clk) begin
    if (por) begin
      m_irp = 0; m_rp = 0; m_to = 1; m_pd = 1; started = 1;
    end else begin
      bit any_f;
      any_f = flg_z_we | flg_dc_we | flg_c_we;
      if (wr_en) begin m_irp = wr_data[7]; m_rp = wr_data[6:5]; end
      if (wdt_to) m_to = 0; else if (clrwdt || sleep_ev) m_to = 1;
      if (sleep_ev) m_pd = 0; else if (clrwdt) m_pd = 1;
      if (flg_z_we) begin m_z = flg_z; kz = 1; end
      else if (wr_en && !any_f) begin m_z = wr_data[2]; kz = 1; end
      if (flg_dc_we) begin m_dc = flg_dc; kdc = 1; end
      else if (wr_en && !any_f) begin m_dc = wr_data[1]; kdc = 1; end
      if (flg_c_we) begin m_c = flg_c; kc = 1; end
      else if (wr_en && !any_f) begin m_c = wr_data[0]; kc = 1; end
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(string pwr_tag);
    if (!started) return;
    check(status[7] == m_irp[0] && status[6:5] == m_rp[1:0], "R4 bank bits", status[7:5], {m_irp[0], m_rp[1:0]});
    check(status[4] == m_to[0], {pwr_tag, " TO"}, status[4], m_to);
    check(status[3] == m_pd[0], {pwr_tag, " PD"}, status[3], m_pd);
    if (kz)  check(status[2] == m_z[0],  "R5 Z",  status[2], m_z);
    if (kdc) check(status[1] == m_dc[0], "R5 DC", status[1], m_dc);
    if (kc)  check(status[0] == m_c[0],  "R5 C",  status[0], m_c);
    check(dir_bank_sel == 4'(1 << m_rp), "R10 sel", dir_bank_sel, 1 << m_rp);
    check(int'(dir_base) == m_rp * 128, "R10 base", dir_base, m_rp * 128);
    check(ind_upper == m_irp[0] && int'(ind_base) == m_irp * 256, "R11 indirect", ind_base, m_irp * 256);
  endtask

  task automatic idle();
    por = 0; wr_en = 0; flg_z_we = 0; flg_dc_we = 0; flg_c_we = 0;
    clrwdt = 0; sleep_ev = 0; wdt_to = 0;
  endtask

  task automatic step(string pwr_tag);
    @(posedge clk);
    @(negedge clk);
    compare(pwr_tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R2");
    check(status[7:3] == 5'b00011, "R2 reset state", status[7:3], 5'b00011);
    idle();
    wr_en = 1; wr_data = 8'hFF; step("R3");
    check(status == 8'hFF, "R1 full byte", status, 8'hFF);
    wr_data = 8'h00; step("R3");
    check(status[4:3] == 2'b11, "R3 write ignored", status[4:3], 2'b11);
    wr_data = 8'h40; step("R3");
    wr_data = 8'hA7; step("R3");
    wr_data = 8'h00; flg_z_we = 1; flg_z = 1; step("R3");
    check(status == 8'h1F, "R5 clear pattern", status, 8'h1F);
    idle(); wr_en = 1; wr_data = 8'hE0; flg_c_we = 1; flg_c = 0; step("R3");
    check(status == 8'hFE, "R5 partial strobe", status, 8'hFE);
    idle(); sleep_ev = 1; step("R7");
    check(status[4:3] == 2'b10, "R7 sleep", status[4:3], 2'b10);
    idle(); clrwdt = 1; step("R6");
    check(status[4:3] == 2'b11, "R6 clrwdt", status[4:3], 2'b11);
    idle(); sleep_ev = 1; clrwdt = 1; step("R7");
    idle(); wdt_to = 1; sleep_ev = 1; step("R8");
    check(status[4:3] == 2'b00, "R8 timeout wins", status[4:3], 2'b00);
    idle(); por = 1; wr_en = 1; wr_data = 8'hFF; flg_z_we = 1; flg_z = 0;
    wdt_to = 1; sleep_ev = 1; step("R9");
    check(status[7:2] == 6'b000111, "R9 por overrides", status[7:2], 6'b000111);
    for (int i = 0; i < 4000; i++) begin
      idle();
      por = ($urandom_range(0, 63) == 0);
      wr_en = $urandom_range(0, 1);
      wr_data = 8'($urandom);
      flg_z_we = ($urandom_range(0, 3) == 0);
      flg_dc_we = ($urandom_range(0, 3) == 0);
      flg_c_we = ($urandom_range(0, 3) == 0);
      {flg_z, flg_dc, flg_c} = 3'($urandom);
      clrwdt = ($urandom_range(0, 7) == 0);
      sleep_ev = ($urandom_range(0, 7) == 0);
      wdt_to = ($urandom_range(0, 7) == 0);
      step("R3");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule